// File: doc/BRIEF.md
# Accumulator Machine Register-Transfer Datapath

This block is the datapath of a small accumulator machine with a 16-bit data word and an 8-bit address. It contains the program counter, the memory address and buffer registers, the opcode register, the ALU operand register, the accumulator and an ALU. Each clock cycle it takes one 32-bit horizontal control word. Fixed bits in that word enable the register transfers, and a 4-bit field in it selects the ALU operation. All transfers selected by one word happen together at the next rising clock edge.

The block connects to a 256 x 16 memory. It drives the memory address and the write data, and it raises write-enable in the same cycle as the write bit of the control word. The read data is captured into the buffer register at the edge that ends the read cycle. A separate microsequencer, outside this block, receives the opcode register and an accumulator-positive flag and uses them to choose the next control word.

Top module: `acc_datapath`

## Requirements
- R1: While reset is asserted, and after it is released, every register holds zero. So `mem_addr`, `mem_wdata` and `opcode` read 0, and `acc_pos` reads 0. The reset is asynchronous and active-low. Its release takes effect after a two-flop synchronizer.
- R2: Control bit 8 clears PC. Bit 10 loads PC from MBR[7:0]. Bit 9 increments PC, wrapping from 255 to 0. When more than one of these bits is set, clear wins over load, and load wins over increment.
- R3: Bit 19 loads MAR from PC and bit 18 loads MAR from MBR[7:0]. If both are set, the MBR source wins. `mem_addr` always shows MAR.
- R4: Bit 16 captures `mem_rdata` into MBR at the clock edge. Bit 20 copies ACC into MBR. If both are set, the memory read wins. `mem_wdata` always shows MBR.
- R5: `mem_we` equals control bit 17 in the same cycle. Memory is then written with MBR at address MAR.
- R6: Bit 21 loads IR from MBR[15:8]. `opcode` shows IR.
- R7: Bit 22 copies MBR into BR. When an ALU operation is in the same word, the ALU uses the MBR value as its second operand.
- R8: ALU code (bits 15:12) 3 gives ACC+BR, 4 gives ACC-BR, and 11 gives the low 16 bits of ACC*BR. The result wraps modulo 2^16 and is written to ACC.
- R9: ALU code 6 gives ACC AND BR, 7 gives ACC OR BR, and 8 gives NOT ACC.
- R10: ALU code 9 shifts ACC right by one and code 10 shifts ACC left by one. Both shifts are logical and fill the vacated bit with 0.
- R11: ALU codes 0, 1, 2, 5 and 12 to 15 leave ACC unchanged.
- R12: Bit 11 clears ACC. It takes priority over any ALU code in the same word.
- R13: `acc_pos` is 1 exactly when ACC, read as signed two's complement, is greater than zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 32 | Horizontal control word for this cycle |
| mem_rdata | input | 16 | Read data of the word at `mem_addr` |
| mem_addr | output | 8 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_we | output | 1 | Memory write enable |
| opcode | output | 8 | Opcode register contents |
| acc_pos | output | 1 | ACC is strictly positive as a signed value |

## Verification
ACC and BR have no port of their own. A wrong accumulator value therefore stays hidden until a copy into MBR brings it onto `mem_wdata`, one edge after that copy. A wrong sign shows on `acc_pos` straight after the edge that wrote ACC. PC is visible only through MAR, so a wrong increment, wrap or priority shows on `mem_addr` one edge after a load of MAR from PC. The operand-forwarding path matters only when a BR copy and an ALU code share a word. A missing forward leaves a stale operand in ACC, and that stale value appears at the next copy to MBR.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

  localparam int unsigned CTRL_W = 32;
  localparam int unsigned ALU_W  = 4;

  // Control word bit positions; the sequencer relies on these.
  localparam int unsigned CB_PC_CLR  = 8;
  localparam int unsigned CB_PC_INC  = 9;
  localparam int unsigned CB_PC_LD   = 10;
  localparam int unsigned CB_ACC_CLR = 11;
  localparam int unsigned CB_ALU_LO  = 12;
  localparam int unsigned CB_MEM_RD  = 16;
  localparam int unsigned CB_MEM_WR  = 17;
  localparam int unsigned CB_MAR_MBR = 18;
  localparam int unsigned CB_MAR_PC  = 19;
  localparam int unsigned CB_MBR_ACC = 20;
  localparam int unsigned CB_IR_LD   = 21;
  localparam int unsigned CB_BR_LD   = 22;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 4'd3,
    ALU_SUB = 4'd4,
    ALU_AND = 4'd6,
    ALU_OR  = 4'd7,
    ALU_NOT = 4'd8,
    ALU_SHR = 4'd9,
    ALU_SHL = 4'd10,
    ALU_MUL = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic             pc_clr;
    logic             pc_inc;
    logic             pc_ld;
    logic             acc_clr;
    logic [ALU_W-1:0] alu;
    logic             mem_rd;
    logic             mem_wr;
    logic             mar_mbr;
    logic             mar_pc;
    logic             mbr_acc;
    logic             ir_ld;
    logic             br_ld;
  } ctrl_s;

  function automatic ctrl_s decode_ctrl(input logic [CTRL_W-1:0] w);
    ctrl_s c;
    c.pc_clr  = w[CB_PC_CLR];
    c.pc_inc  = w[CB_PC_INC];
    c.pc_ld   = w[CB_PC_LD];
    c.acc_clr = w[CB_ACC_CLR];
    c.alu     = w[CB_ALU_LO +: ALU_W];
    c.mem_rd  = w[CB_MEM_RD];
    c.mem_wr  = w[CB_MEM_WR];
    c.mar_mbr = w[CB_MAR_MBR];
    c.mar_pc  = w[CB_MAR_PC];
    c.mbr_acc = w[CB_MBR_ACC];
    c.ir_ld   = w[CB_IR_LD];
    c.br_ld   = w[CB_BR_LD];
    return c;
  endfunction

endpackage

// File: rtl/acc_dp_rst_sync.sv
module acc_dp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/acc_dp_alu.sv
module acc_dp_alu
  import acc_dp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [ALU_W-1:0]  op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y,
  output logic              valid
);
  always_comb begin
    y     = a;
    valid = 1'b1;
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOT: y = ~a;
      ALU_SHR: y = {1'b0, a[DATA_W-1:1]};
      ALU_SHL: y = {a[DATA_W-2:0], 1'b0};
      ALU_MUL: y = a * b;
      default: valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_dp_addr.sv
module acc_dp_addr #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_clr,
  input  logic              pc_inc,
  input  logic              pc_ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              mar_pc,
  input  logic              mar_mbr,
  input  logic [ADDR_W-1:0] mar_val,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] mar_o
);
  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic              pc_en, mar_en;

  always_comb begin
    pc_en = pc_clr | pc_ld | pc_inc;
    if (pc_clr)     pc_d = '0;
    else if (pc_ld) pc_d = ld_val;
    else            pc_d = pc_q + 1'b1;

    mar_en = mar_pc | mar_mbr;
    mar_d  = mar_mbr ? mar_val : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;

  p_pc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_clr |=> pc_q == '0);
  p_pc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_ld && !pc_clr) |=> pc_q == $past(ld_val));
  p_pc_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_inc && !pc_ld && !pc_clr) |=> pc_q == $past(pc_q) + 1'b1);
  p_mar_mbr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mar_mbr |=> mar_q == $past(mar_val));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OP_W     = 8,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [OP_W-1:0]   opcode,
  output logic              acc_pos
);
  localparam int unsigned OP_LO = DATA_W - OP_W;

  ctrl_s c;
  logic  rst_s_n;

  logic [DATA_W-1:0] mbr_q, mbr_d, br_q, acc_q, acc_d, alu_b, alu_y;
  logic [OP_W-1:0]   ir_q;
  logic [ADDR_W-1:0] pc_w, mar_w;
  logic              mbr_en, acc_en, alu_valid;
  logic              unused_ctrl;
  logic [ADDR_W-1:0] unused_pc;

  assign c           = decode_ctrl(ctrl_word);
  assign unused_ctrl = ^{ctrl_word[CB_PC_CLR-1:0], ctrl_word[CTRL_W-1:CB_BR_LD+1]};
  assign unused_pc   = pc_w;

  acc_dp_rst_sync #(.STAGES(RST_SYNC)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  acc_dp_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .pc_clr  (c.pc_clr),
    .pc_inc  (c.pc_inc),
    .pc_ld   (c.pc_ld),
    .ld_val  (mbr_q[ADDR_W-1:0]),
    .mar_pc  (c.mar_pc),
    .mar_mbr (c.mar_mbr),
    .mar_val (mbr_q[ADDR_W-1:0]),
    .pc_o    (pc_w),
    .mar_o   (mar_w)
  );

  acc_dp_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (c.alu),
    .a     (acc_q),
    .b     (alu_b),
    .y     (alu_y),
    .valid (alu_valid)
  );

  always_comb begin
    mbr_en = c.mem_rd | c.mbr_acc;
    mbr_d  = c.mem_rd ? mem_rdata : acc_q;
    alu_b  = c.br_ld ? mbr_q : br_q;
    acc_en = c.acc_clr | alu_valid;
    acc_d  = c.acc_clr ? '0 : alu_y;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mbr_q <= '0;
      br_q  <= '0;
      ir_q  <= '0;
      acc_q <= '0;
    end else begin
      if (mbr_en)  mbr_q <= mbr_d;
      if (c.br_ld) br_q  <= mbr_q;
      if (c.ir_ld) ir_q  <= mbr_q[DATA_W-1:OP_LO];
      if (acc_en)  acc_q <= acc_d;
    end
  end

  assign mem_addr  = mar_w;
  assign mem_wdata = mbr_q;
  assign mem_we    = c.mem_wr;
  assign opcode    = ir_q;
  assign acc_pos   = ~acc_q[DATA_W-1] & (|acc_q);

  p_mbr_read_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    c.mem_rd |=> mbr_q == $past(mem_rdata));
  p_ir_load_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    c.ir_ld |=> opcode == $past(mbr_q[DATA_W-1:OP_LO]));
  p_shl_zero_fill_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (c.alu == ALU_SHL) |=> acc_q[0] == 1'b0);
  p_acc_hold_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!c.acc_clr && !alu_valid) |=> $stable(acc_q));
  p_acc_clear_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    c.acc_clr |=> (acc_q == '0 && !acc_pos));
endmodule

// File: tb/sim_acc_datapath.sv
`timescale 1ns/1ps
module sim_acc_datapath;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ctrl;
  logic [15:0] mem_rdata;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [7:0]  opcode;
  logic        acc_pos;

  logic [15:0] mem [256];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [31:0] W_PC_CLR  = 32'h1 << 8;
  localparam logic [31:0] W_PC_INC  = 32'h1 << 9;
  localparam logic [31:0] W_PC_LD   = 32'h1 << 10;
  localparam logic [31:0] W_ACC_CLR = 32'h1 << 11;
  localparam logic [31:0] W_MEM_RD  = 32'h1 << 16;
  localparam logic [31:0] W_MEM_WR  = 32'h1 << 17;
  localparam logic [31:0] W_MAR_MBR = 32'h1 << 18;
  localparam logic [31:0] W_MAR_PC  = 32'h1 << 19;
  localparam logic [31:0] W_MBR_ACC = 32'h1 << 20;
  localparam logic [31:0] W_IR_LD   = 32'h1 << 21;
  localparam logic [31:0] W_BR_LD   = 32'h1 << 22;

  // {alu code, a, b, expected ACC}
  localparam int NV = 13;
  localparam logic [51:0] VEC [NV] = '{
    {4'd3,  16'h1234, 16'h0FF1, 16'h2225},
    {4'd3,  16'hFFFF, 16'h0002, 16'h0001},
    {4'd4,  16'h0005, 16'h0007, 16'hFFFE},
    {4'd6,  16'hF0F0, 16'h3C3C, 16'h3030},
    {4'd7,  16'hF0F0, 16'h0F01, 16'hFFF1},
    {4'd8,  16'h00FF, 16'h1234, 16'hFF00},
    {4'd9,  16'h8001, 16'h0000, 16'h4000},
    {4'd10, 16'h8001, 16'h0000, 16'h0002},
    {4'd11, 16'h0100, 16'h0123, 16'h2300},
    {4'd11, 16'h0007, 16'h0009, 16'h003F},
    {4'd0,  16'h5A5A, 16'h0001, 16'h5A5A},
    {4'd5,  16'h1111, 16'h2222, 16'h1111},
    {4'd15, 16'h7FFF, 16'h0003, 16'h7FFF}
  };

  acc_datapath u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .opcode    (opcode),
    .acc_pos   (acc_pos)
  );

  always #2 clk = ~clk;

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] w);
    ctrl = w;
    @(negedge clk);
    ctrl = '0;
  endtask

  function automatic logic [31:0] alu_w(input logic [3:0] code);
    return {16'h0, code, 12'h0};
  endfunction

  function automatic bit pos16(input logic [15:0] v);
    return !v[15] && v != 16'h0;
  endfunction

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    rst_n = 1'b0;
    ctrl  = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_addr == 8'h0,   "R1 mem_addr", {24'h0, mem_addr}, 0);
    check(mem_wdata == 16'h0, "R1 mem_wdata", {16'h0, mem_wdata}, 0);
    check(opcode == 8'h0,     "R1 opcode", {24'h0, opcode}, 0);
    check(acc_pos == 1'b0,    "R1 acc_pos", {31'h0, acc_pos}, 0);
    check(mem_we == 1'b0,     "R5 mem_we idle", {31'h0, mem_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mem_addr == 8'h0 && mem_wdata == 16'h0, "R1 after release", {8'h0, mem_addr, mem_wdata}, 0);

    // Vector table: R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  code;
      logic [15:0] a, b, e;
      {code, a, b, e} = VEC[i];
      mem[0] = a;
      mem[1] = b;
      step(W_PC_CLR);
      step(W_MAR_PC);
      step(W_MEM_RD);
      step(W_BR_LD | W_ACC_CLR);
      step(alu_w(4'd3));
      step(W_PC_INC);
      step(W_MAR_PC);
      step(W_MEM_RD);
      step(W_BR_LD);
      step(alu_w(code));
      check(acc_pos == pos16(e), $sformatf("R13 flag vec%0d", i), {31'h0, acc_pos}, {31'h0, pos16(e)});
      step(W_MBR_ACC);
      check(mem_wdata == e, $sformatf("R8/R9/R10/R11 vec%0d code %0d", i, code), {16'h0, mem_wdata}, {16'h0, e});
    end

    // R2 R3 R4 R6: PC, MAR, MBR, IR
    mem[0] = 16'h12FE;
    step(W_PC_CLR);
    step(W_MAR_PC);
    check(mem_addr == 8'h00, "R3 MAR from PC", {24'h0, mem_addr}, 0);
    step(W_MEM_RD);
    check(mem_wdata == 16'h12FE, "R4 read into MBR", {16'h0, mem_wdata}, 32'h12FE);
    step(W_IR_LD);
    check(opcode == 8'h12, "R6 IR from MBR high", {24'h0, opcode}, 32'h12);
    step(W_PC_LD);
    step(W_MAR_PC);
    check(mem_addr == 8'hFE, "R2 PC load", {24'h0, mem_addr}, 32'hFE);
    step(W_PC_INC);
    step(W_MAR_PC);
    check(mem_addr == 8'hFF, "R2 PC increment", {24'h0, mem_addr}, 32'hFF);
    step(W_PC_INC);
    step(W_MAR_PC);
    check(mem_addr == 8'h00, "R2 PC wrap", {24'h0, mem_addr}, 0);
    step(W_PC_LD);
    step(W_PC_CLR | W_PC_INC | W_PC_LD);
    step(W_MAR_PC);
    check(mem_addr == 8'h00, "R2 clear priority", {24'h0, mem_addr}, 0);
    step(W_PC_INC | W_PC_LD);
    step(W_MAR_PC);
    check(mem_addr == 8'hFE, "R2 load over increment", {24'h0, mem_addr}, 32'hFE);
    step(W_PC_CLR);
    step(W_MAR_MBR | W_MAR_PC);
    check(mem_addr == 8'hFE, "R3 MBR source wins", {24'h0, mem_addr}, 32'hFE);

    // R5 write
    ctrl = W_MEM_WR;
    #1;
    check(mem_we == 1'b1, "R5 we follows bit", {31'h0, mem_we}, 1);
    @(negedge clk);
    ctrl = '0;
    #1;
    check(mem_we == 1'b0, "R5 we drops", {31'h0, mem_we}, 0);
    check(mem[8'hFE] == 16'h12FE, "R5 memory written", {16'h0, mem[8'hFE]}, 32'h12FE);
    @(negedge clk);

    // R4 priority (ACC = 7FFF from last vector)
    step(W_MBR_ACC);
    check(mem_wdata == 16'h7FFF, "R4 ACC copy", {16'h0, mem_wdata}, 32'h7FFF);
    step(W_MEM_RD | W_MBR_ACC);
    check(mem_wdata == 16'h12FE, "R4 read wins", {16'h0, mem_wdata}, 32'h12FE);

    // R12 clear beats ALU
    step(W_ACC_CLR | alu_w(4'd3));
    check(acc_pos == 1'b0, "R13 zero not positive", {31'h0, acc_pos}, 0);
    step(W_MBR_ACC);
    check(mem_wdata == 16'h0, "R12 clear priority", {16'h0, mem_wdata}, 0);

    // R7 forwarding: BR holds 0003, MBR becomes 12FE
    step(W_MEM_RD);
    step(W_BR_LD | alu_w(4'd3));
    check(acc_pos == 1'b1, "R13 positive", {31'h0, acc_pos}, 1);
    step(W_MBR_ACC);
    check(mem_wdata == 16'h12FE, "R7 forwarded operand", {16'h0, mem_wdata}, 32'h12FE);
    step(alu_w(4'd8));
    check(acc_pos == 1'b0, "R13 negative", {31'h0, acc_pos}, 0);
    step(W_MBR_ACC);
    check(mem_wdata == 16'hED01, "R9 invert", {16'h0, mem_wdata}, 32'hED01);

    // R1 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    check(opcode == 8'h0 && mem_wdata == 16'h0, "R1 async reset", {8'h0, opcode, mem_wdata}, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule